// File: doc/BRIEF.md
# Dual-Input Long-Press Reset Generator

This block turns a deliberate two-button press into a single system reset. It watches two active-low manual request pins. Only when both pins are low at the same time does it start a countdown, and the countdown begins at the moment the later of the two pins falls. If the pins stay low for the whole selected timeout, the block produces exactly one active-low reset pulse. If either pin is released early, the countdown is abandoned and starts over from zero.

Both pins pass through two-flop synchronizers into the system clock domain. A prescaler derives a 0.1 ms sub-tick, and ten sub-ticks make a 1 ms tick. The timeout is counted in milliseconds and the pulse width in sub-ticks. A 3-bit select picks one of eight timeouts. A build-time parameter picks a short or a long pulse. The output is a pull-low enable: it models an open-drain pin that either sinks the line or releases it, so several such outputs can share one reset line.

Top module: `lpr_reset_gen`

## Requirements
- R1: A countdown starts only when both synchronized pins are low, and it starts when the later of the two falls, whichever pin that is. The pull-low enable rises exactly 2 + T×10×DIV clock edges after the edge that first samples the second low pin. DIV is CLK_HZ/10000 and T is the timeout in ms.
- R2: Before that edge the pull-low enable stays 0. At that edge it becomes 1.
- R3: If either pin goes high before the countdown ends, the count is discarded. A fresh, full countdown starts when both pins are low again.
- R4: The select `tsel` maps its codes to timeouts in ascending order: 0→500, 1→1000, 2→1500, 3→2000, 4→2500, 5→3000, 6→4000 and 7→5000 ms. It is captured when a countdown starts, and changing it during a countdown has no effect on that countdown.
- R5: The pulse lasts 22 sub-ticks (2.2 ms) when PULSE_LONG is 0 and 700 sub-ticks (70 ms) when it is 1, that is 22×DIV or 700×DIV clock cycles.
- R6: While both pins stay low after a pulse, no further pulse is produced. Raising either pin and lowering it again arms a new full countdown.
- R7: After reset the pull-low enable is 0, and no pulse occurs without a complete countdown.
- R8: Once a pulse has started it runs to its full width, even if the pins are released during it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mr_a_n | input | 1 | First manual request pin, active low, asynchronous |
| mr_b_n | input | 1 | Second manual request pin, active low, asynchronous |
| tsel | input | 3 | Timeout select code, captured when a countdown starts |
| rst_pull_en | output | 1 | 1 = sink the shared reset line low, 0 = release it |

## Verification
Two events can fall on the same clock edge: the pins being released and the controller entering its pulse. The bench provokes this by raising both pins in the very cycle the pulse first appears, and it judges the case by requiring the full pulse width anyway. A second overlap is a select change while the countdown is counting. The bench changes the code mid-count and requires the deadline of the code captured at the start. A third is a one-cycle release late in a countdown. For that case the bench checks that no pulse appears at the old deadline and that one appears exactly one full timeout after the pins fall again.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

  // Sub-tick rate used for both the millisecond count and the pulse width.
  localparam int SUBTICK_HZ     = 10000;
  localparam int SUBTICKS_PER_MS = 10;
  localparam int TMO_W          = 13;   // holds up to 5000 ms
  localparam int SHORT_PULSE_SUB = 22;  // 2.2 ms
  localparam int LONG_PULSE_SUB  = 700; // 70 ms

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_COUNT,
    ST_PULSE,
    ST_HOLD
  } lpr_state_e;

  // Timeout in ms for a select code, ascending.
  function automatic logic [TMO_W-1:0] timeout_ms(input logic [2:0] code);
    int unsigned v;
    if (code < 3'd6) v = (32'(code) + 32'd1) * 32'd500;
    else             v = (32'(code) - 32'd2) * 32'd1000;
    return TMO_W'(v);
  endfunction

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/lpr_prescaler.sv
module lpr_prescaler #(
  parameter int DIV = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);

  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/lpr_ctrl.sv
module lpr_ctrl
  import lpr_pkg::*;
#(
  parameter int PULSE_SUB = SHORT_PULSE_SUB
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       both_low,
  input  logic [2:0] tsel,
  input  logic       sub_tick,
  output logic       presc_clr,
  output logic       pull_en
);

  localparam int PW_W = $clog2(PULSE_SUB + 1);
  localparam int DEC_W = $clog2(SUBTICKS_PER_MS);
  localparam logic [PW_W-1:0]  PW_LAST  = PW_W'(PULSE_SUB - 1);
  localparam logic [DEC_W-1:0] DEC_LAST = DEC_W'(SUBTICKS_PER_MS - 1);

  lpr_state_e       state;
  logic [TMO_W-1:0] limit_ms;
  logic [TMO_W-1:0] ms_cnt;
  logic [DEC_W-1:0] dec_cnt;
  logic [PW_W-1:0]  pw_cnt;

  assign presc_clr = (state == ST_IDLE) || (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      limit_ms <= '0;
      ms_cnt   <= '0;
      dec_cnt  <= '0;
      pw_cnt   <= '0;
      pull_en  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (both_low) begin
            state    <= ST_COUNT;
            limit_ms <= timeout_ms(tsel);
            ms_cnt   <= '0;
            dec_cnt  <= '0;
          end
        end
        ST_COUNT: begin
          if (!both_low) begin
            state <= ST_IDLE;
          end else if (sub_tick) begin
            if (dec_cnt == DEC_LAST) begin
              dec_cnt <= '0;
              if (ms_cnt == limit_ms - 1'b1) begin
                state   <= ST_PULSE;
                pull_en <= 1'b1;
                pw_cnt  <= '0;
              end else begin
                ms_cnt <= ms_cnt + 1'b1;
              end
            end else begin
              dec_cnt <= dec_cnt + 1'b1;
            end
          end
        end
        ST_PULSE: begin
          if (sub_tick) begin
            if (pw_cnt == PW_LAST) begin
              state   <= ST_HOLD;
              pull_en <= 1'b0;
            end else begin
              pw_cnt <= pw_cnt + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (!both_low) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lpr_reset_gen.sv
module lpr_reset_gen
  import lpr_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter bit PULSE_LONG = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mr_a_n,
  input  logic       mr_b_n,
  input  logic [2:0] tsel,
  output logic       rst_pull_en
);

  localparam int DIV       = CLK_HZ / SUBTICK_HZ;
  localparam int PULSE_SUB = PULSE_LONG ? LONG_PULSE_SUB : SHORT_PULSE_SUB;

  logic [1:0] pins_sync;
  logic       both_low;
  logic       sub_tick;
  logic       presc_clr;

  lpr_sync #(
    .WIDTH  (2),
    .STAGES (2),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({mr_b_n, mr_a_n}),
    .q  (pins_sync)
  );

  assign both_low = (pins_sync == 2'b00);

  lpr_prescaler #(
    .DIV(DIV)
  ) u_presc (
    .clk (clk),
    .rst (rst),
    .clr (presc_clr),
    .tick(sub_tick)
  );

  lpr_ctrl #(
    .PULSE_SUB(PULSE_SUB)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .both_low (both_low),
    .tsel     (tsel),
    .sub_tick (sub_tick),
    .presc_clr(presc_clr),
    .pull_en  (rst_pull_en)
  );

endmodule

// File: rtl/lpr_reset_gen_chk.sv
module lpr_reset_gen_chk #(
  parameter int CLK_HZ     = 50_000_000,
  parameter bit PULSE_LONG = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic mr_a_n,
  input logic mr_b_n,
  input logic rst_pull_en
);

  localparam int DIV     = CLK_HZ / 10000;
  localparam int PW_CYC  = (PULSE_LONG ? 700 : 22) * DIV;
  localparam int MIN_CYC = 5000 * DIV;

  int   hi_len;
  int   low_run;
  logic seen_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len    <= 0;
      low_run   <= 0;
      seen_high <= 1'b1;
    end else begin
      hi_len <= rst_pull_en ? hi_len + 1 : 0;
      if (!mr_a_n && !mr_b_n) low_run <= (low_run < MIN_CYC) ? low_run + 1 : low_run;
      else                    low_run <= 0;
      if (mr_a_n || mr_b_n)   seen_high <= 1'b1;
      else if (rst_pull_en)   seen_high <= 1'b0;
    end
  end

  // R7: reset forces the line released
  a_r7_reset_release: assert property (@(posedge clk) rst |=> !rst_pull_en);

  // R1, R2: a pulse needs both pins held low for at least the shortest timeout
  a_r2_min_low_time: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pull_en) |-> (low_run >= MIN_CYC));

  // R5, R8: a finished pulse has exactly the configured width
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_pull_en) |-> (hi_len == PW_CYC));

  // R8: a pulse never outlasts its width
  a_r8_no_overrun: assert property (@(posedge clk) disable iff (rst)
    rst_pull_en |-> (hi_len < PW_CYC));

  // R6: a new pulse needs a pin to have gone high since the last one
  a_r6_one_per_press: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_pull_en) |-> seen_high);

endmodule

bind lpr_reset_gen lpr_reset_gen_chk #(
  .CLK_HZ    (CLK_HZ),
  .PULSE_LONG(PULSE_LONG)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mr_a_n     (mr_a_n),
  .mr_b_n     (mr_b_n),
  .rst_pull_en(rst_pull_en)
);

// File: tb/tb_lpr_reset_gen.sv
module tb_lpr_reset_gen;

  localparam int CLK_PERIOD = 10;
  localparam int TB_CLK_HZ  = 10000;   // one sub-tick per clock
  localparam int DIV        = TB_CLK_HZ / 10000;
  localparam int PW_S       = 22 * DIV;
  localparam int PW_L       = 700 * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mr_a_n = 1'b1;
  logic       mr_b_n = 1'b1;
  logic [2:0] tsel = 3'd0;
  logic       pull_s;
  logic       pull_l;

  int checks = 0;
  int errors = 0;
  int rise_cnt = 0;
  logic prev_pull = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpr_reset_gen #(.CLK_HZ(TB_CLK_HZ), .PULSE_LONG(1'b0)) dut (
    .clk(clk), .rst(rst), .mr_a_n(mr_a_n), .mr_b_n(mr_b_n),
    .tsel(tsel), .rst_pull_en(pull_s));

  lpr_reset_gen #(.CLK_HZ(TB_CLK_HZ), .PULSE_LONG(1'b1)) dut_long (
    .clk(clk), .rst(rst), .mr_a_n(mr_a_n), .mr_b_n(mr_b_n),
    .tsel(tsel), .rst_pull_en(pull_l));

  always @(negedge clk) begin
    if (pull_s && !prev_pull) rise_cnt++;
    prev_pull = pull_s;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tmo_ms(input int code);
    return (code < 6) ? (code + 1) * 500 : (code - 2) * 1000;
  endfunction

  // Called at the negedge where the last pin was lowered.
  task automatic pulse_check(input int ms, input string req, input bit release_mid,
                             input bit with_long);
    int n  = ms * 10 * DIV;
    int r0 = rise_cnt;
    repeat (n + 2) @(posedge clk);
    @(negedge clk);
    chk(pull_s == 1'b0 && rise_cnt == r0, {req, " no pulse before deadline"},
        int'(pull_s), 0);
    @(posedge clk);
    @(negedge clk);
    chk(pull_s == 1'b1, {req, " R2 pulse at deadline"}, int'(pull_s), 1);
    if (release_mid) begin
      mr_a_n = 1'b1;
      mr_b_n = 1'b1;
    end
    repeat (PW_S - 1) @(posedge clk);
    @(negedge clk);
    chk(pull_s == 1'b1, {req, " R5 pulse last cycle"}, int'(pull_s), 1);
    @(posedge clk);
    @(negedge clk);
    chk(pull_s == 1'b0, {req, " R5 pulse end"}, int'(pull_s), 0);
    if (with_long) begin
      repeat (PW_L - PW_S - 1) @(posedge clk);
      @(negedge clk);
      chk(pull_l == 1'b1, "R5 long pulse last cycle", int'(pull_l), 1);
      @(posedge clk);
      @(negedge clk);
      chk(pull_l == 1'b0, "R5 long pulse end", int'(pull_l), 0);
    end
  endtask

  task automatic release_all();
    @(negedge clk);
    mr_a_n = 1'b1;
    mr_b_n = 1'b1;
    repeat (PW_L + 10) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    repeat (5) @(negedge clk);
    chk(pull_s == 1'b0, "R7 output during reset", int'(pull_s), 0);
    rst = 1'b0;
    repeat (100) @(negedge clk);
    chk(pull_s == 1'b0 && pull_l == 1'b0 && rise_cnt == 0, "R7 quiet after reset",
        int'(pull_s), 0);

    // A first then B (R1), code 0, short and long widths (R5)
    @(negedge clk); tsel = 3'd0; mr_a_n = 1'b0;
    repeat (3) @(negedge clk); mr_b_n = 1'b0;
    pulse_check(tmo_ms(0), "R1 a-first", 1'b0, 1'b1);

    // R6: held low, no repeat
    r0 = rise_cnt;
    repeat (3000) @(negedge clk);
    chk(rise_cnt == r0 && pull_s == 1'b0, "R6 no repeat while held", rise_cnt - r0, 0);
    // R6: brief release of B re-arms
    mr_b_n = 1'b1;
    @(negedge clk); mr_b_n = 1'b0;
    pulse_check(tmo_ms(0), "R6 re-arm", 1'b0, 1'b0);
    release_all();

    // R4 sweep, B first then A (R1)
    foreach (sweep_codes[i]) begin
      @(negedge clk); tsel = sweep_codes[i]; mr_b_n = 1'b0;
      repeat (4) @(negedge clk); mr_a_n = 1'b0;
      pulse_check(tmo_ms(sweep_codes[i]), "R4 code sweep", 1'b0, 1'b0);
      release_all();
    end

    // R3: early release restarts from zero
    @(negedge clk); tsel = 3'd0; mr_a_n = 1'b0; mr_b_n = 1'b0;
    repeat (4000) @(negedge clk);
    mr_a_n = 1'b1;
    @(negedge clk); mr_a_n = 1'b0;
    pulse_check(tmo_ms(0), "R3 restart", 1'b0, 1'b0);
    release_all();

    // R4: select change mid-count ignored
    @(negedge clk); tsel = 3'd0; mr_a_n = 1'b0; mr_b_n = 1'b0;
    fork
      begin repeat (100) @(negedge clk); tsel = 3'd7; end
    join_none
    pulse_check(tmo_ms(0), "R4 sel captured", 1'b0, 1'b0);
    release_all();

    // R8: release at first pulse cycle, full width still required
    @(negedge clk); tsel = 3'd0; mr_a_n = 1'b0; mr_b_n = 1'b0;
    pulse_check(tmo_ms(0), "R8 release mid-pulse", 1'b1, 1'b0);
    release_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [2:0] sweep_codes [5] = '{3'd1, 3'd2, 3'd3, 3'd7, 3'd4};

endmodule